// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the command front end of a 16-bit NOR flash bank, written as behavioural logic. A host issues bus writes to the bank, each one a single-clock strobe that carries an address and a data word. The block recognises the unlock-guarded command sequences among those writes: word program, sector erase, block erase, chip erase, erase suspend and resume, and entry to and exit from the identification mode. When a sequence is accepted, the block emits a one-cycle start pulse with the operation kind, the target address and, for a program, the data word. It then holds a busy indication for a parameterised number of cycles, which stands in for the program or erase time of the array.

During a running operation the block refuses commands. The only exception is that a running sector or block erase can be paused and later continued. While an erase is paused, words may be programmed anywhere outside the paused region. A write-protect input guards the lowest 8 KWord of the address space. A separate active-low abort input ends any activity at once. The nonvolatile array, analog timing and glitch filtering are not part of the block.

Top module: `flash_cmd_seq`

## Requirements
- R1: After `rst`, `busy`, `suspended`, `id_mode` and `op_start` are 0 and `id_word` is 0000h.
- R2: The writes 555h/AAh, 2AAh/55h, 555h/A0h followed by a write of word D at address A produce a one-cycle `op_start` with `op_kind`=1 (program), `op_addr`=A and `op_data`=D. `busy` is then high for PROG_CYC cycles, counted from the cycle in which `op_start` is high.
- R3: In command cycles only address bits 10..0 are compared with 555h and 2AAh, and data bits 15..8 are ignored.
- R4: The six writes 555h/AAh, 2AAh/55h, 555h/80h, 555h/AAh, 2AAh/55h, then a final write start an erase lasting ERASE_CYC cycles. A final write of 50h at address A gives `op_kind`=2 (sector, A20..A11 selects a 2 KWord sector). A final write of 30h at A gives `op_kind`=3 (block, A20..A15 selects a 32 KWord block). A final write of 10h at 555h gives `op_kind`=4 (chip). A final 10h at any other low address starts nothing.
- R5: A write that does not match the expected step of a sequence discards the partial sequence, so the writes that follow it start nothing.
- R6: While a program or chip erase runs, every write is ignored, including B0h and F0h and complete command sequences.
- R7: While a sector or block erase runs, a write of B0h to any address clears `busy` after SUSP_CYC cycles and sets `suspended`. A later write of 30h to any address clears `suspended` and runs the erase for its remaining cycles, so the total run time stays ERASE_CYC.
- R8: While suspended, a program outside the suspended sector or block starts, with `suspended` kept high. A program inside that region is refused.
- R9: The writes 555h/AAh, 2AAh/55h, 555h/90h set `id_mode`. In ID mode `id_word` reads 00BFh at `rd_addr` 0, 7353h at `rd_addr` 1 and 0000h elsewhere, one cycle after the address. A single F0h at any address, or 555h/AAh, 2AAh/55h, 555h/F0h, clears `id_mode`. An F0h written while `busy` is high is ignored.
- R10: With `wp_n` low, programs and sector or block erases that touch addresses whose bits 20..13 are all zero are refused, and a chip erase is refused. With `wp_n` high they start.
- R11: Driving `hw_reset_n` low for one cycle clears `busy`, `suspended` and `id_mode`. An erase that was suspended at that moment cannot be resumed afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_reset_n | input | 1 | Synchronous active-low abort of any activity |
| wp_n | input | 1 | Low protects the lowest 8 KWord |
| wr_stb | input | 1 | One-cycle bus write strobe |
| wr_addr | input | 21 | Word address of the bus write |
| wr_data | input | 16 | Data of the bus write |
| rd_addr | input | 21 | Read address for identification words |
| op_start | output | 1 | One-cycle pulse when an operation starts |
| op_kind | output | 3 | 1 program, 2 sector, 3 block, 4 chip erase |
| op_addr | output | 21 | Target address of the operation |
| op_data | output | 16 | Program data word |
| busy | output | 1 | Operation running or suspend pending |
| suspended | output | 1 | An erase is paused |
| id_mode | output | 1 | Identification mode active |
| id_word | output | 16 | Identification word for `rd_addr` |

## Verification
The bench replaces each write of an erase sequence in turn with a stray write, then continues with the remaining writes. A decoder that did not drop its partial state would then launch an erase. It sets one high address bit at a time in the unlock cycles, which a decoder comparing too many address bits would reject. It sweeps all eight sectors at the bottom of the space with protection on, to catch an off-by-one in the protected span. It also times busy around a suspend and resume. A design that lost or double-counted the interrupted cycle would finish early or late, and one that let resume survive the abort input would go busy again.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_PROG = 3'd1,
    OP_SECT = 3'd2,
    OP_BLK  = 3'd3,
    OP_CHIP = 3'd4
  } op_kind_t;

  typedef enum logic [2:0] {
    ST_READY,
    ST_RUN,
    ST_HALT,
    ST_PAUSE,
    ST_PRUN
  } ctl_state_t;

  typedef struct packed {
    logic prog;
    logic sect;
    logic blk;
    logic chip;
    logic id_in;
    logic id_out;
    logic susp;
    logic resume;
  } cmd_req_t;

endpackage

// File: rtl/flash_unlock_dec.sv
module flash_unlock_dec
  import flash_cmd_pkg::*;
#(
  parameter int CMP_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             abort,
  input  logic             seq_en,
  input  logic             wr_stb,
  input  logic [CMP_W-1:0] lo_addr,
  input  logic [7:0]       dat,
  output cmd_req_t         req
);

  localparam logic [CMP_W-1:0] KEY_A = CMP_W'('h555);
  localparam logic [CMP_W-1:0] KEY_B = CMP_W'('h2AA);

  logic [2:0] step;
  logic       at_a, at_b;

  assign at_a = (lo_addr == KEY_A);
  assign at_b = (lo_addr == KEY_B);

  always_comb begin
    req = '0;
    if (wr_stb) begin
      case (step)
        3'd0: begin
          req.id_out = (dat == 8'hF0);
          req.resume = (dat == 8'h30);
          req.susp   = (dat == 8'hB0);
        end
        3'd2: begin
          req.id_in  = at_a && (dat == 8'h90);
          req.id_out = at_a && (dat == 8'hF0);
        end
        3'd3: req.prog = 1'b1;
        3'd6: begin
          req.sect = (dat == 8'h50);
          req.blk  = (dat == 8'h30);
          req.chip = at_a && (dat == 8'h10);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || abort || !seq_en) begin
      step <= 3'd0;
    end else if (wr_stb) begin
      case (step)
        3'd0: step <= (at_a && dat == 8'hAA) ? 3'd1 : 3'd0;
        3'd1: step <= (at_b && dat == 8'h55) ? 3'd2 : 3'd0;
        3'd2: step <= !at_a ? 3'd0 : (dat == 8'hA0) ? 3'd3 : (dat == 8'h80) ? 3'd4 : 3'd0;
        3'd4: step <= (at_a && dat == 8'hAA) ? 3'd5 : 3'd0;
        3'd5: step <= (at_b && dat == 8'h55) ? 3'd6 : 3'd0;
        default: step <= 3'd0;
      endcase
    end
  end

  // R6
  idle_step_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(seq_en) |-> !(req.prog || req.sect || req.blk || req.chip || req.id_in));

endmodule

// File: rtl/flash_op_ctrl.sv
module flash_op_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int AW        = 21,
  parameter int DW        = 16,
  parameter int PROG_CYC  = 8,
  parameter int ERASE_CYC = 40,
  parameter int SUSP_CYC  = 4,
  parameter int SECT_BITS = 11,
  parameter int BLK_BITS  = 15,
  parameter int PROT_BITS = 13
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          abort,
  input  logic          wp_n,
  input  cmd_req_t      req,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          seq_en,
  output logic          op_start,
  output logic [2:0]    op_kind,
  output logic [AW-1:0] op_addr,
  output logic [DW-1:0] op_data,
  output logic          busy,
  output logic          suspended,
  output logic          id_mode
);

  localparam int MAXC = (ERASE_CYC > PROG_CYC) ?
                        ((ERASE_CYC > SUSP_CYC) ? ERASE_CYC : SUSP_CYC) :
                        ((PROG_CYC > SUSP_CYC) ? PROG_CYC : SUSP_CYC);
  localparam int CW = $clog2(MAXC + 1);
  localparam logic [CW-1:0] ONE       = CW'(1);
  localparam logic [CW-1:0] PROG_LEN  = CW'(PROG_CYC);
  localparam logic [CW-1:0] ERASE_LEN = CW'(ERASE_CYC);
  localparam logic [CW-1:0] SUSP_LEN  = CW'(SUSP_CYC);

  ctl_state_t    st;
  op_kind_t      kind_q, sav_kind, new_kind;
  logic [CW-1:0] cnt, sav_cnt;
  logic [AW-1:0] sav_addr;
  logic          id_q;
  logic          ready, paused, guard, in_susp;
  logic          ok_prog, ok_sect, ok_blk, ok_chip, launch;

  function automatic logic hits_prot(input logic [AW-1:0] a, input int span);
    int top;
    top = (span > PROT_BITS) ? span : PROT_BITS;
    return ((a >> top) == '0);
  endfunction

  assign ready  = (st == ST_READY);
  assign paused = (st == ST_PAUSE);
  assign guard  = !wp_n;
  assign in_susp = (sav_kind == OP_SECT) ?
                   ((wr_addr >> SECT_BITS) == (sav_addr >> SECT_BITS)) :
                   ((wr_addr >> BLK_BITS) == (sav_addr >> BLK_BITS));

  assign ok_prog = req.prog && (ready || paused) &&
                   !(guard && hits_prot(wr_addr, 0)) && !(paused && in_susp);
  assign ok_sect = req.sect && ready && !(guard && hits_prot(wr_addr, SECT_BITS));
  assign ok_blk  = req.blk  && ready && !(guard && hits_prot(wr_addr, BLK_BITS));
  assign ok_chip = req.chip && ready && !guard;
  assign launch  = ok_prog || ok_sect || ok_blk || ok_chip;

  always_comb begin
    new_kind = OP_NONE;
    if (ok_prog)      new_kind = OP_PROG;
    else if (ok_sect) new_kind = OP_SECT;
    else if (ok_blk)  new_kind = OP_BLK;
    else if (ok_chip) new_kind = OP_CHIP;
  end

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      st       <= ST_READY;
      cnt      <= '0;
      sav_cnt  <= '0;
      sav_kind <= OP_NONE;
      sav_addr <= '0;
      kind_q   <= OP_NONE;
      op_addr  <= '0;
      op_data  <= '0;
      op_start <= 1'b0;
      id_q     <= 1'b0;
    end else begin
      op_start <= 1'b0;
      if (ready || paused) begin
        if (req.id_in)       id_q <= 1'b1;
        else if (req.id_out) id_q <= 1'b0;
      end
      case (st)
        ST_READY: if (launch) begin
          op_start <= 1'b1;
          kind_q   <= new_kind;
          op_addr  <= wr_addr;
          op_data  <= wr_data;
          cnt      <= ok_prog ? PROG_LEN : ERASE_LEN;
          st       <= ST_RUN;
        end
        ST_RUN: begin
          if (cnt == ONE) begin
            st <= ST_READY;
          end else if (req.susp && (kind_q == OP_SECT || kind_q == OP_BLK)) begin
            st       <= ST_HALT;
            sav_cnt  <= cnt - ONE;
            sav_kind <= kind_q;
            sav_addr <= op_addr;
            cnt      <= SUSP_LEN;
          end else begin
            cnt <= cnt - ONE;
          end
        end
        ST_HALT: begin
          if (cnt == ONE) st <= ST_PAUSE;
          else            cnt <= cnt - ONE;
        end
        ST_PAUSE: begin
          if (ok_prog) begin
            op_start <= 1'b1;
            kind_q   <= OP_PROG;
            op_addr  <= wr_addr;
            op_data  <= wr_data;
            cnt      <= PROG_LEN;
            st       <= ST_PRUN;
          end else if (req.resume) begin
            kind_q  <= sav_kind;
            op_addr <= sav_addr;
            cnt     <= sav_cnt;
            st      <= ST_RUN;
          end
        end
        ST_PRUN: begin
          if (cnt == ONE) st <= ST_PAUSE;
          else            cnt <= cnt - ONE;
        end
        default: st <= ST_READY;
      endcase
    end
  end

  assign seq_en    = ready || paused;
  assign op_kind   = kind_q;
  assign busy      = (st == ST_RUN) || (st == ST_HALT) || (st == ST_PRUN);
  assign suspended = (st == ST_PAUSE) || (st == ST_PRUN);
  assign id_mode   = id_q;

  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (rst)
    op_start |-> busy);

  // R2
  start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    op_start |=> !op_start);

  // R6
  busy_lockout_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(busy) && !$past(abort)) |-> !op_start);

  // R8
  susp_prog_only_chk: assert property (@(posedge clk) disable iff (rst)
    (op_start && suspended) |-> (op_kind == OP_PROG));

  // R10
  chip_wp_chk: assert property (@(posedge clk) disable iff (rst)
    (op_start && op_kind == OP_CHIP) |-> $past(wp_n));

  // R11
  abort_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $past(abort) |-> (!busy && !suspended && !id_mode));

endmodule

// File: rtl/flash_id_rd.sv
module flash_id_rd #(
  parameter int             AW     = 21,
  parameter int             DW     = 16,
  parameter logic [DW-1:0]  ID_MFR = DW'('h00BF),
  parameter logic [DW-1:0]  ID_DEV = DW'('h7353)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          id_mode,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] id_word
);

  localparam logic [AW-1:0] OFS_MFR = AW'(0);
  localparam logic [AW-1:0] OFS_DEV = AW'(1);

  always_ff @(posedge clk) begin
    if (rst || !id_mode)           id_word <= '0;
    else if (rd_addr == OFS_MFR)   id_word <= ID_MFR;
    else if (rd_addr == OFS_DEV)   id_word <= ID_DEV;
    else                           id_word <= '0;
  end

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_cmd_pkg::*;
#(
  parameter int AW        = 21,
  parameter int DW        = 16,
  parameter int CMP_W     = 11,
  parameter int PROG_CYC  = 8,
  parameter int ERASE_CYC = 40,
  parameter int SUSP_CYC  = 4,
  parameter int SECT_BITS = 11,
  parameter int BLK_BITS  = 15,
  parameter int PROT_BITS = 13
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hw_reset_n,
  input  logic          wp_n,
  input  logic          wr_stb,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic          op_start,
  output logic [2:0]    op_kind,
  output logic [AW-1:0] op_addr,
  output logic [DW-1:0] op_data,
  output logic          busy,
  output logic          suspended,
  output logic          id_mode,
  output logic [DW-1:0] id_word
);

  logic     abort;
  logic     seq_en;
  cmd_req_t req;

  assign abort = !hw_reset_n;

  flash_unlock_dec #(.CMP_W(CMP_W)) u_dec (
    .clk     (clk),
    .rst     (rst),
    .abort   (abort),
    .seq_en  (seq_en),
    .wr_stb  (wr_stb),
    .lo_addr (wr_addr[CMP_W-1:0]),
    .dat     (wr_data[7:0]),
    .req     (req)
  );

  flash_op_ctrl #(
    .AW(AW), .DW(DW), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC),
    .SUSP_CYC(SUSP_CYC), .SECT_BITS(SECT_BITS), .BLK_BITS(BLK_BITS),
    .PROT_BITS(PROT_BITS)
  ) u_ctl (
    .clk       (clk),
    .rst       (rst),
    .abort     (abort),
    .wp_n      (wp_n),
    .req       (req),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .seq_en    (seq_en),
    .op_start  (op_start),
    .op_kind   (op_kind),
    .op_addr   (op_addr),
    .op_data   (op_data),
    .busy      (busy),
    .suspended (suspended),
    .id_mode   (id_mode)
  );

  flash_id_rd #(.AW(AW), .DW(DW)) u_id (
    .clk     (clk),
    .rst     (rst),
    .id_mode (id_mode),
    .rd_addr (rd_addr),
    .id_word (id_word)
  );

endmodule

// File: tb/flash_cmd_seq_tb.sv
module flash_cmd_seq_tb;

  localparam int CLK_P = 10;
  localparam int AW    = 21;
  localparam int PROG  = 5;
  localparam int ERASE = 16;
  localparam int SUSP  = 3;

  logic          clk = 0;
  logic          rst = 1;
  logic          hw_reset_n = 1;
  logic          wp_n = 1;
  logic          wr_stb = 0;
  logic [AW-1:0] wr_addr = '0;
  logic [15:0]   wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic          op_start, busy, suspended, id_mode;
  logic [2:0]    op_kind;
  logic [AW-1:0] op_addr;
  logic [15:0]   op_data, id_word;

  int nchk = 0, nfail = 0, starts = 0;

  always #(CLK_P/2) clk = ~clk;

  flash_cmd_seq #(.PROG_CYC(PROG), .ERASE_CYC(ERASE), .SUSP_CYC(SUSP)) u_dut (
    .clk(clk), .rst(rst), .hw_reset_n(hw_reset_n), .wp_n(wp_n),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .op_start(op_start), .op_kind(op_kind), .op_addr(op_addr), .op_data(op_data),
    .busy(busy), .suspended(suspended), .id_mode(id_mode), .id_word(id_word)
  );

  always @(negedge clk) if (op_start) starts++;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
    wr_addr = a; wr_data = d; wr_stb = 1;
    @(negedge clk);
    wr_stb = 0;
  endtask

  task automatic unlock3(input logic [7:0] c);
    wr(21'h555, 16'h00AA); wr(21'h2AA, 16'h0055); wr(21'h555, {8'h00, c});
  endtask

  task automatic prog(input logic [AW-1:0] a, input logic [15:0] d);
    unlock3(8'hA0); wr(a, d);
  endtask

  task automatic erase(input logic [AW-1:0] a, input logic [7:0] c);
    unlock3(8'h80); wr(21'h555, 16'h00AA); wr(21'h2AA, 16'h0055); wr(a, {8'h00, c});
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (busy && n < 1000) begin n++; @(negedge clk); end
  endtask

  task automatic expect_op(input string tag, input logic [2:0] k, input logic [AW-1:0] a,
                           input logic [15:0] d, input bit with_d, input int dur);
    int n;
    chk(op_start == 1'b1, {tag, " start"}, op_start, 1);
    chk(op_kind == k, {tag, " kind"}, op_kind, k);
    chk(op_addr == a, {tag, " addr"}, op_addr, a);
    if (with_d) chk(op_data == d, {tag, " data"}, op_data, d);
    @(negedge clk);
    chk(op_start == 1'b0, {tag, " pulse width"}, op_start, 0);
    busy_len(n);
    chk(n + 1 == dur, {tag, " busy cycles"}, n + 1, dur);
  endtask

  task automatic expect_none(input string tag, input int s0);
    @(negedge clk);
    chk(starts == s0, {tag, " no start"}, starts, s0);
    chk(busy == 1'b0, {tag, " not busy"}, busy, 0);
  endtask

  task automatic pulse_abort();
    hw_reset_n = 0; @(negedge clk); hw_reset_n = 1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    int s0, m;
    logic [AW-1:0] ea [6];
    logic [15:0]   ed [6];
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R1 reset state
    chk(busy == 0, "R1 busy", busy, 0);
    chk(suspended == 0, "R1 suspended", suspended, 0);
    chk(id_mode == 0, "R1 id_mode", id_mode, 0);
    chk(op_start == 0, "R1 op_start", op_start, 0);
    chk(id_word == 0, "R1 id_word", id_word, 0);

    // R2 plain program
    prog(21'h12345, 16'hBEEF);
    expect_op("R2 program", 3'd1, 21'h12345, 16'hBEEF, 1, PROG);

    // R3 each high address bit set in the unlock cycles, high data byte garbage
    for (int b = 11; b < AW; b++) begin
      logic [AW-1:0] hb;
      hb = AW'(1) << b;
      wr(hb | 21'h555, {8'(b), 8'hAA});
      wr(hb | 21'h2AA, {8'(b + 1), 8'h55});
      wr(hb | 21'h555, {8'hFF, 8'hA0});
      wr(21'h3000 + AW'(b), 16'h1000 + 16'(b));
      expect_op("R3 masked compare", 3'd1, 21'h3000 + AW'(b), 16'h1000 + 16'(b), 1, PROG);
    end

    // R4 erase kinds
    erase(21'h05A00, 8'h50);
    expect_op("R4 sector", 3'd2, 21'h05A00, 16'h0, 0, ERASE);
    erase(21'h18000, 8'h30);
    expect_op("R4 block", 3'd3, 21'h18000, 16'h0, 0, ERASE);
    erase(21'h1FF555, 8'h10);
    expect_op("R4 chip", 3'd4, 21'h1FF555, 16'h0, 0, ERASE);
    s0 = starts;
    erase(21'h554, 8'h10);
    expect_none("R4 chip wrong address", s0);

    // R5 corrupt each step of a sector erase sequence
    ea = '{21'h555, 21'h2AA, 21'h555, 21'h555, 21'h2AA, 21'h05A00};
    ed = '{16'h00AA, 16'h0055, 16'h0080, 16'h00AA, 16'h0055, 16'h0050};
    for (int s = 0; s < 6; s++) begin
      s0 = starts;
      for (int i = 0; i < 6; i++) begin
        if (i == s) wr(21'h123, 16'h0000);
        else        wr(ea[i], ed[i]);
      end
      expect_none($sformatf("R5 corrupt step %0d", s), s0);
    end

    // R6 lockout during chip erase
    erase(21'h555, 8'h10);
    chk(op_start == 1, "R6 chip started", op_start, 1);
    s0 = starts + 1;
    prog(21'h4000, 16'h1111);
    wr(21'h0, 16'h00B0);
    wr(21'h0, 16'h00F0);
    chk(suspended == 0, "R6 no suspend in chip erase", suspended, 0);
    busy_len(m);
    chk(m + 6 == ERASE, "R6 chip erase length", m + 6, ERASE);
    chk(starts == s0, "R6 no start while busy", starts, s0);
    // R6 lockout during program
    prog(21'h4100, 16'h2222);
    s0 = starts + 1;
    wr(21'h0, 16'h00B0);
    chk(suspended == 0, "R6 no suspend in program", suspended, 0);
    busy_len(m);
    chk(m + 1 == PROG, "R6 program length", m + 1, PROG);
    chk(starts == s0, "R6 program single start", starts, s0);

    // R7 suspend a sector erase
    erase(21'h06800, 8'h50);
    wr(21'h1ABCD, 16'h00B0);
    busy_len(m);
    chk(m == SUSP, "R7 suspend latency", m, SUSP);
    chk(suspended == 1, "R7 suspended", suspended, 1);
    // R8 program inside suspended sector refused, outside allowed
    s0 = starts;
    prog(21'h06A00, 16'h3333);
    @(negedge clk);
    chk(starts == s0, "R8 inside region refused", starts, s0);
    chk(suspended == 1, "R8 still suspended", suspended, 1);
    prog(21'h07000, 16'h4444);
    chk(suspended == 1, "R8 suspended during program", suspended, 1);
    expect_op("R8 program outside", 3'd1, 21'h07000, 16'h4444, 1, PROG);
    chk(suspended == 1, "R8 back to suspended", suspended, 1);
    // R7 resume
    wr(21'h777, 16'h0030);
    chk(suspended == 0, "R7 resume clears suspended", suspended, 0);
    busy_len(m);
    chk(m == ERASE - 1, "R7 remaining erase", m, ERASE - 1);

    // R8 block suspend region, then R11 abort drops the suspended erase
    erase(21'h18000, 8'h30);
    wr(21'h0, 16'h00B0);
    busy_len(m);
    s0 = starts;
    prog(21'h1C000, 16'h5555);
    @(negedge clk);
    chk(starts == s0, "R8 inside block refused", starts, s0);
    prog(21'h20000, 16'h6666);
    expect_op("R8 program outside block", 3'd1, 21'h20000, 16'h6666, 1, PROG);
    pulse_abort();
    chk(suspended == 0, "R11 abort clears suspend", suspended, 0);
    wr(21'h0, 16'h0030);
    chk(busy == 0, "R11 no resume after abort", busy, 0);
    prog(21'h4200, 16'h7777);
    pulse_abort();
    chk(busy == 0, "R11 abort ends program", busy, 0);

    // R9 identification mode
    unlock3(8'h90);
    chk(id_mode == 1, "R9 entry", id_mode, 1);
    for (int o = 0; o < 3; o++) begin
      rd_addr = AW'(o);
      @(negedge clk);
      chk(id_word == (o == 0 ? 16'h00BF : o == 1 ? 16'h7353 : 16'h0000),
          "R9 id word", id_word, (o == 0 ? 16'h00BF : o == 1 ? 16'h7353 : 16'h0000));
    end
    wr(21'h0ABC, 16'h00F0);
    chk(id_mode == 0, "R9 single exit", id_mode, 0);
    rd_addr = '0;
    @(negedge clk);
    chk(id_word == 0, "R9 word after exit", id_word, 0);
    unlock3(8'h90);
    unlock3(8'hF0);
    chk(id_mode == 0, "R9 three-cycle exit", id_mode, 0);
    unlock3(8'h90);
    prog(21'h4300, 16'h8888);
    wr(21'h0, 16'h00F0);
    chk(id_mode == 1, "R9 exit ignored while busy", id_mode, 1);
    busy_len(m);
    wr(21'h0, 16'h00F0);
    chk(id_mode == 0, "R9 exit after busy", id_mode, 0);
    unlock3(8'h90);
    pulse_abort();
    chk(id_mode == 0, "R11 abort leaves id mode", id_mode, 0);

    // R10 write protection
    wp_n = 0;
    s0 = starts; prog(21'h01FFF, 16'h1); expect_none("R10 program protected", s0);
    prog(21'h02000, 16'h2);
    expect_op("R10 program above span", 3'd1, 21'h02000, 16'h2, 1, PROG);
    for (int k = 0; k < 8; k++) begin
      s0 = starts;
      erase(AW'(k * 'h800), 8'h50);
      if (k >= 4) expect_op($sformatf("R10 sector %0d", k), 3'd2, AW'(k * 'h800), 16'h0, 0, ERASE);
      else        expect_none($sformatf("R10 sector %0d protected", k), s0);
    end
    s0 = starts; erase(21'h00000, 8'h30); expect_none("R10 block 0 protected", s0);
    erase(21'h08000, 8'h30);
    expect_op("R10 block 1", 3'd3, 21'h08000, 16'h0, 0, ERASE);
    s0 = starts; erase(21'h555, 8'h10); expect_none("R10 chip refused", s0);
    wp_n = 1;
    prog(21'h00000, 16'h9);
    expect_op("R10 unprotected program", 3'd1, 21'h00000, 16'h9, 1, PROG);
    erase(21'h00000, 8'h50);
    expect_op("R10 unprotected sector", 3'd2, 21'h00000, 16'h0, 0, ERASE);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

endmodule